// File: doc/BRIEF.md
# Separate-I/O Static Memory with Selectable Write-Output Behaviour

This block is a clocked model of a static memory with independent data-in and data-out buses. Access is gated by two active-low selects; an active-low write strobe and an active-low output enable complete the control set. All four controls, the address and the input data are sampled on the system clock. A write lasts for as long as both selects and the write strobe are all sampled low. It is committed to the array on the first clock after that overlap ends, using the address and data sampled in the last cycle of the overlap.

A build-time parameter `WMODE` fixes what the output does during a write. `WM_HIGHZ` turns the output off while the write strobe is low. `WM_PASS` makes the output follow the data being written. Because the output is an ordinary two-state bus, "high impedance" is shown by `dout_en` low, with `dout` forced to zero. When either select is high the block is deselected and raises `standby`.

The array holds 2^ADDR_W words of DATA_W bits. Setting ADDR_W = 14 and DATA_W = 4 gives the full 16K x 4 organisation. The default build uses ADDR_W = 12 to keep the elaborated array small.

Top module: `sepio_sram`

## Requirements
- R1: After reset, and before any input has been sampled, `standby` = 1, `dout_en` = 0 and `dout` = 0.
- R2: A write is committed only for cycles in which `sel1_n`, `sel2_n` and `wr_n` are all sampled 0. The word stored is the address and data sampled in the last such cycle of the overlap. The commit happens when any one of the three controls is sampled 1, whichever rises first.
- R3: A read is a cycle with both selects sampled 0, `wr_n` sampled 1 and `oe_n` sampled 0. In the cycle that follows that clock edge, the read drives `dout_en` = 1 and `dout` = the stored word at the sampled address.
- R4: If either select is sampled 1, then `dout_en` = 0 and `dout` = 0 in the following cycle, whatever the other inputs are.
- R5: If `oe_n` is sampled 1, then `dout_en` = 0 and `dout` = 0.
- R6: With WMODE = WM_HIGHZ, `dout_en` = 0 while `wr_n` is sampled 0. It also stays 0 when a select and `wr_n` rise in the same cycle.
- R7: With WMODE = WM_PASS, a write cycle with `oe_n` = 0 gives `dout_en` = 1 and `dout` = the `din` sampled in that cycle.
- R8: A read of the address being committed, sampled in the first cycle after the write overlap ends, returns the newly written word.
- R9: A cycle with `wr_n` = 0 but a select at 1 leaves the memory unchanged.
- R10: `standby` = 1 exactly when either select was sampled 1 at the last clock edge, and 0 when both were sampled 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the control state |
| sel1_n | input | 1 | First active-low select |
| sel2_n | input | 1 | Second active-low select |
| wr_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output enable |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, zero when not driven |
| dout_en | output | 1 | High when `dout` is actively driven |
| standby | output | 1 | High while deselected (power-down) |

## Verification
Every output is a function of the inputs sampled at the most recent rising edge, together with the array and the pending-write register. A stimulus driven before edge k is therefore visible in the cycle right after edge k. The bench drives at the falling edge and compares at edge k plus a quarter period. A write reaches the array one edge later still. Reads issued in the cycle just after a write ends are checked against the forwarded word, and later reads are checked against the bench's shadow array.

// File: rtl/sepio_pkg.sv
package sepio_pkg;
   typedef enum logic {
      WM_HIGHZ = 1'b0,
      WM_PASS  = 1'b1
   } wmode_e;

   typedef struct packed {
      logic sel1_n;
      logic sel2_n;
      logic wr_n;
      logic oe_n;
   } ctl_t;

   localparam ctl_t CTL_IDLE = '{sel1_n: 1'b1, sel2_n: 1'b1, wr_n: 1'b1, oe_n: 1'b1};
endpackage

// File: rtl/sepio_sampler.sv
module sepio_sampler #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  sepio_pkg::ctl_t     ctl_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [DATA_W-1:0]   din_i,
   output sepio_pkg::ctl_t     ctl_q,
   output logic [ADDR_W-1:0]   addr_q,
   output logic [DATA_W-1:0]   din_q,
   output logic                selected,
   output logic                overlap
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= sepio_pkg::CTL_IDLE;
         addr_q <= '0;
         din_q  <= '0;
      end else begin
         ctl_q  <= ctl_i;
         addr_q <= addr_i;
         din_q  <= din_i;
      end
   end

   always_comb begin
      selected = !ctl_q.sel1_n && !ctl_q.sel2_n;
      overlap  = selected && !ctl_q.wr_n;
   end
endmodule

// File: rtl/sepio_write_ctl.sv
module sepio_write_ctl #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                overlap,
   input  logic [ADDR_W-1:0]   addr_q,
   input  logic [DATA_W-1:0]   din_q,
   output logic                pend,
   output logic [ADDR_W-1:0]   pend_addr,
   output logic [DATA_W-1:0]   pend_data,
   output logic                commit
);
   assign commit = pend && !overlap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend      <= 1'b0;
         pend_addr <= '0;
         pend_data <= '0;
      end else if (overlap) begin
         pend      <= 1'b1;
         pend_addr <= addr_q;
         pend_data <= din_q;
      end else if (commit) begin
         pend      <= 1'b0;
      end
   end

   AST_COMMIT_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(overlap) |-> commit) else $error("write end not committed"); // R2
   AST_COMMIT_NEEDS_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> $past(overlap)) else $error("commit without prior overlap"); // R2
endmodule

// File: rtl/sepio_array.sv
module sepio_array #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 4
) (
   input  logic                clk,
   input  logic                we,
   input  logic [ADDR_W-1:0]   waddr,
   input  logic [DATA_W-1:0]   wdata,
   input  logic                fwd_valid,
   input  logic [ADDR_W-1:0]   raddr,
   output logic [DATA_W-1:0]   rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   always_comb begin
      if (fwd_valid && (waddr == raddr)) rdata = wdata;
      else                                rdata = cells[raddr];
   end
endmodule

// File: rtl/sepio_out_stage.sv
module sepio_out_stage #(
   parameter int               DATA_W = 4,
   parameter sepio_pkg::wmode_e WMODE = sepio_pkg::WM_HIGHZ
) (
   input  logic                clk,
   input  logic                rst_n,
   input  sepio_pkg::ctl_t     ctl_q,
   input  logic                selected,
   input  logic                overlap,
   input  logic [DATA_W-1:0]   din_q,
   input  logic [DATA_W-1:0]   rdata,
   output logic [DATA_W-1:0]   dout,
   output logic                dout_en
);
   logic              drive;
   logic [DATA_W-1:0] src;

   generate
      if (WMODE == sepio_pkg::WM_HIGHZ) begin : g_highz
         assign drive = selected && !ctl_q.oe_n && ctl_q.wr_n;
         assign src   = rdata;
         AST_HIGHZ_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            overlap |-> !dout_en) else $error("output driven during write"); // R6
      end else begin : g_pass
         assign drive = selected && !ctl_q.oe_n;
         assign src   = overlap ? din_q : rdata;
      end
   endgenerate

   assign dout_en = drive;
   assign dout    = drive ? src : '0;

   AST_OE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q.oe_n |-> (!dout_en && dout == '0)) else $error("output on with oe high"); // R5
endmodule

// File: rtl/sepio_sram.sv
module sepio_sram #(
   parameter int                ADDR_W = 12,
   parameter int                DATA_W = 4,
   parameter sepio_pkg::wmode_e WMODE  = sepio_pkg::WM_HIGHZ
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel1_n,
   input  logic              sel2_n,
   input  logic              wr_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en,
   output logic              standby
);
   generate
      if (ADDR_W < 1 || ADDR_W > 20) begin : g_bad_addr
         $error("ADDR_W out of supported range");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be positive");
      end
   endgenerate

   sepio_pkg::ctl_t   ctl_in, ctl_q;
   logic [ADDR_W-1:0] addr_q, pend_addr;
   logic [DATA_W-1:0] din_q, pend_data, rdata;
   logic              selected, overlap, pend, commit;

   assign ctl_in = '{sel1_n: sel1_n, sel2_n: sel2_n, wr_n: wr_n, oe_n: oe_n};

   sepio_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_smp (
      .clk(clk), .rst_n(rst_n), .ctl_i(ctl_in), .addr_i(addr), .din_i(din),
      .ctl_q(ctl_q), .addr_q(addr_q), .din_q(din_q),
      .selected(selected), .overlap(overlap));

   sepio_write_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wctl (
      .clk(clk), .rst_n(rst_n), .overlap(overlap), .addr_q(addr_q), .din_q(din_q),
      .pend(pend), .pend_addr(pend_addr), .pend_data(pend_data), .commit(commit));

   sepio_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
      .clk(clk), .we(commit), .waddr(pend_addr), .wdata(pend_data),
      .fwd_valid(pend), .raddr(addr_q), .rdata(rdata));

   sepio_out_stage #(.DATA_W(DATA_W), .WMODE(WMODE)) u_out (
      .clk(clk), .rst_n(rst_n), .ctl_q(ctl_q), .selected(selected), .overlap(overlap),
      .din_q(din_q), .rdata(rdata), .dout(dout), .dout_en(dout_en));

   assign standby = !selected;

   AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      standby |-> (!dout_en && dout == '0)) else $error("output on while deselected"); // R4
   AST_STANDBY_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(sel1_n) && !$past(sel2_n)) |-> !standby) else $error("standby while selected"); // R10
endmodule

// File: tb/sepio_sram_tb_top.sv
module sepio_sram_tb_top;
   localparam int AW = 12;
   localparam int DW = 4;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic s1 = 1'b1, s2 = 1'b1, w = 1'b1, oe = 1'b1;
   logic [AW-1:0] a = '0;
   logic [DW-1:0] d = '0;
   logic [DW-1:0] dout_h, dout_p;
   logic en_h, en_p, sb_h, sb_p;

   int vectors = 0;
   int miscompares = 0;
   bit done = 0;

   logic [DW-1:0] shadow [DEPTH];
   bit            known  [DEPTH];
   bit            pv = 0;
   logic [AW-1:0] pa = '0;
   logic [DW-1:0] pd = '0;

   always #10 clk = ~clk;

   sepio_sram #(.ADDR_W(AW), .DATA_W(DW), .WMODE(sepio_pkg::WM_HIGHZ)) dut_i (
      .clk(clk), .rst_n(rst_n), .sel1_n(s1), .sel2_n(s2), .wr_n(w), .oe_n(oe),
      .addr(a), .din(d), .dout(dout_h), .dout_en(en_h), .standby(sb_h));

   sepio_sram #(.ADDR_W(AW), .DATA_W(DW), .WMODE(sepio_pkg::WM_PASS)) dut_pass_i (
      .clk(clk), .rst_n(rst_n), .sel1_n(s1), .sel2_n(s2), .wr_n(w), .oe_n(oe),
      .addr(a), .din(d), .dout(dout_p), .dout_en(en_p), .standby(sb_p));

   task automatic cmp(string tag, string what, logic [7:0] act, logic [7:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic bit exp_known(logic [AW-1:0] ad);
      return (pv && pa == ad) ? 1'b1 : known[ad];
   endfunction

   function automatic logic [DW-1:0] exp_word(logic [AW-1:0] ad);
      return (pv && pa == ad) ? pd : shadow[ad];
   endfunction

   task automatic step(logic ns1, logic ns2, logic nw, logic noe,
                       logic [AW-1:0] na, logic [DW-1:0] nd, string tag);
      bit sel, ov, eh, ep, kn;
      logic [DW-1:0] wd;
      @(negedge clk);
      s1 = ns1; s2 = ns2; w = nw; oe = noe; a = na; d = nd;
      @(posedge clk);
      #5;
      sel = !ns1 && !ns2;
      ov  = sel && !nw;
      eh  = sel && !noe && nw;
      ep  = sel && !noe;
      kn  = exp_known(na);
      wd  = exp_word(na);
      cmp(tag, "standby_h", {7'd0, sb_h}, {7'd0, !sel});
      cmp(tag, "standby_p", {7'd0, sb_p}, {7'd0, !sel});
      cmp(tag, "en_h", {7'd0, en_h}, {7'd0, eh});
      cmp(tag, "en_p", {7'd0, en_p}, {7'd0, ep});
      if (!eh) cmp(tag, "dout_h off", {4'd0, dout_h}, 8'd0);
      else if (kn) cmp(tag, "dout_h", {4'd0, dout_h}, {4'd0, wd});
      if (!ep) cmp(tag, "dout_p off", {4'd0, dout_p}, 8'd0);
      else if (ov) cmp(tag, "dout_p pass", {4'd0, dout_p}, {4'd0, nd});
      else if (kn) cmp(tag, "dout_p", {4'd0, dout_p}, {4'd0, wd});
      if (ov) begin
         pv = 1; pa = na; pd = nd;
      end else if (pv) begin
         shadow[pa] = pd; known[pa] = 1; pv = 0;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 20);
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) known[i] = 0;
      void'($urandom(32'd4711));
      repeat (3) @(posedge clk);
      #5;
      // R1 reset state
      cmp("R1", "standby", {7'd0, sb_h}, 8'd1);
      cmp("R1", "en_h", {7'd0, en_h}, 8'd0);
      cmp("R1", "en_p", {7'd0, en_p}, 8'd0);
      cmp("R1", "dout_h", {4'd0, dout_h}, 8'd0);
      @(negedge clk);
      rst_n = 1'b1;
      // R2 write ended by wr_n, R8 immediate read of committed word, R7 pass-through
      step(0, 0, 0, 0, 12'd5, 4'hA, "R7");
      step(0, 0, 0, 0, 12'd5, 4'hA, "R6");
      step(0, 0, 1, 0, 12'd5, 4'h0, "R8");
      step(0, 0, 1, 0, 12'd5, 4'h0, "R3");
      // R2 write ended by a select rising while wr_n stays low
      step(0, 0, 0, 1, 12'd9, 4'h3, "R2");
      step(1, 0, 0, 1, 12'd9, 4'h3, "R4");
      step(0, 0, 1, 0, 12'd9, 4'h0, "R2");
      // R2 only the last sampled address/data of an overlap is stored
      step(0, 0, 0, 1, 12'd20, 4'h7, "R2");
      step(0, 0, 1, 1, 12'd20, 4'h0, "R5");
      step(0, 0, 0, 1, 12'd20, 4'h1, "R2");
      step(0, 0, 0, 1, 12'd21, 4'h2, "R2");
      step(0, 0, 1, 0, 12'd0, 4'h0, "R2");
      step(0, 0, 1, 0, 12'd21, 4'h0, "R2");
      step(0, 0, 1, 0, 12'd20, 4'h0, "R2");
      // R9 write strobe with a select high does nothing
      step(0, 1, 0, 0, 12'd5, 4'hF, "R9");
      step(1, 1, 0, 0, 12'd5, 4'hE, "R9");
      step(0, 0, 1, 0, 12'd5, 4'h0, "R9");
      // R6 select and write strobe rising together
      step(0, 0, 0, 0, 12'd30, 4'h6, "R6");
      step(1, 0, 1, 0, 12'd30, 4'h0, "R6");
      step(0, 0, 1, 0, 12'd30, 4'h0, "R3");
      // R5 output enable high during read
      step(0, 0, 1, 1, 12'd30, 4'h0, "R5");
      // R10 standby with each select alone
      step(1, 0, 1, 0, 12'd30, 4'h0, "R10");
      step(0, 1, 1, 0, 12'd30, 4'h0, "R10");
      // constrained random mix over a small address window
      for (int i = 0; i < 800; i++) begin
         logic [31:0] r;
         r = $urandom();
         step(r[2:0] == 3'd0, r[5:3] == 3'd0, r[7:6] != 2'd0, r[10:8] == 3'd0,
              12'd100 + {9'd0, r[13:11]}, r[17:14], "R3");
      end
      finish_run();
   end
endmodule